// File: doc/BRIEF.md
# E4 Byte-Alignment Frame Synchronizer

This block sits behind a deserializer whose 8-bit output words land on arbitrary bit boundaries. It keeps the last seven received bits next to the current byte. From that 15-bit window it tests all eight possible bit offsets at once for the 12-bit E4 frame alignment word `1111_1010_0000`. When the leading byte `0xFA` shows up at some offset, the block freezes its 3-bit alignment select there. The next byte at that offset must carry a zero upper nibble, or the select is released.

A frame counter then predicts where each later alignment word must sit, 366 accepted bytes further on. Three good frames in a row at the predicted slot declare frame sync. Once in sync, four bad frames in a row drop it and restart the search. The output is the byte stream realigned to the frozen offset.

Data enters and leaves over valid/ready. The block holds a single output register. It accepts an input byte only when that register is empty or is being drained in the same cycle, so `in_ready` follows `out_ready` with no extra storage. A held output byte stays constant until it is taken. The frame counter advances on accepted bytes only, so gaps and stalls do not move the frame position.

Top module: `e4_frame_aligner`

## Requirements
- R1: During and right after a synchronous active-high reset, `out_valid`, `in_frame`, `fa_found` and `nib_found` are 0 and `align_sel` is 0.
- R2: Bits are taken MSB first: bit 7 of each input byte arrived earliest. The window is the previous byte's bits 6..0 placed above the current byte (window bit 14 is the oldest). Offset k is window bits k+7..k. When searching and offset k holds `0xFA`, the clock edge that accepts that byte sets `align_sel` to k and pulses `fa_found` for one cycle. The lowest matching offset wins.
- R3: Every byte accepted from the detection byte onward appears on `out_data` one accepted byte later, taken at the frozen offset. The first byte out is `0xFA`.
- R4: The byte accepted right after a detection is checked at the frozen offset. An upper nibble of zero pulses `nib_found`. Any other value releases the select and resumes the search, and that detection counts for nothing.
- R5: The expected slot of each later alignment word is 366 accepted bytes after the previous one. `in_frame` rises on the edge that accepts the nibble byte of the third consecutive good frame, together with a `nib_found` pulse.
- R6: Before sync, a frame whose expected slot lacks `0xFA` followed by a zero nibble sends the block back to the search.
- R7: While confirming or in sync, an alignment byte at any other offset or position is ignored: `align_sel` does not change and `fa_found` does not pulse.
- R8: In sync, one bad frame does not clear `in_frame`. Four consecutive bad frames clear it on the edge that accepts the fourth one's nibble byte, and the search resumes.
- R9: `in_ready` is 1 exactly when the output register is empty or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Raw byte present |
| in_ready | output | 1 | Block takes the raw byte this cycle |
| in_data | input | 8 | Raw deserializer byte, bit 7 earliest |
| out_valid | output | 1 | Aligned byte present |
| out_ready | input | 1 | Consumer takes the aligned byte |
| out_data | output | 8 | Byte realigned to the frozen offset |
| align_sel | output | 3 | Frozen bit offset |
| in_frame | output | 1 | Frame sync declared |
| fa_found | output | 1 | One-cycle pulse: alignment byte accepted |
| nib_found | output | 1 | One-cycle pulse: trailing zero nibble confirmed |

## Verification
The stream is a serial alignment-word-plus-alternating-payload sequence, shifted by 0 to 7 junk bits. Sweeping all eight shifts tells each offset decoder apart from its neighbours, and checks that lowest-bit mapping is not mirrored. Further runs plant single faults. A corrupt trailing nibble separates release from a stuck freeze. A missing word in the second frame separates pre-sync fall-back from loss counting. A spurious word in the payload separates slot-gated checking from free detection. One isolated bad frame followed by four separates the single-error tolerance from the loss threshold. Input gaps and output stalls are applied throughout, so the data scoreboard also tests that frame counting follows accepted bytes rather than clock cycles.

// File: rtl/e4fa_pkg.sv
package e4fa_pkg;
  localparam int LANES = 8;
  localparam int LANE_IW = $clog2(LANES);
  localparam logic [11:0] ALIGN_WORD = 12'b1111_1010_0000;
  localparam logic [7:0] ALIGN_HEAD = ALIGN_WORD[11:4];
  typedef enum logic [1:0] {ST_SEARCH, ST_CHECK, ST_SYNC} fsm_t;
  typedef logic [LANES-1:0][7:0] lanes_t;
endpackage

// File: rtl/e4fa_window.sv
module e4fa_window
  import e4fa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic [7:0] din,
  output lanes_t     lanes
);
  localparam int HW = LANES - 1;
  localparam int WW = HW + 8;

  logic [HW-1:0] hist;
  logic [WW-1:0] wnd;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else if (adv) hist <= din[HW-1:0];
  end

  assign wnd = {hist, din};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes[k] = wnd[k+7:k];
  end
endmodule

// File: rtl/e4fa_detect.sv
module e4fa_detect
  import e4fa_pkg::*;
(
  input  lanes_t             lanes,
  output logic               hit,
  output logic [LANE_IW-1:0] hit_idx
);
  logic [LANES-1:0] match;

  for (genvar k = 0; k < LANES; k++) begin : g_dec
    assign match[k] = (lanes[k] == ALIGN_HEAD);
  end

  always_comb begin
    hit = |match;
    hit_idx = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (match[k]) hit_idx = LANE_IW'(k);
    end
  end
endmodule

// File: rtl/e4fa_ctrl.sv
module e4fa_ctrl
  import e4fa_pkg::*;
#(
  parameter int FRAME_BYTES = 366,
  parameter int CONFIRM_FRAMES = 3,
  parameter int LOSS_FRAMES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  lanes_t             lanes,
  input  logic               hit,
  input  logic [LANE_IW-1:0] hit_idx,
  output logic [LANE_IW-1:0] sel,
  output logic [LANE_IW-1:0] cur_sel,
  output logic               in_frame,
  output logic               fa_stb,
  output logic               nib_stb
);
  localparam int PW = $clog2(FRAME_BYTES);
  localparam int GW = $clog2(CONFIRM_FRAMES + 1);
  localparam int MW = $clog2(LOSS_FRAMES + 1);

  fsm_t          state;
  logic [PW-1:0] pos;
  logic [GW-1:0] good;
  logic [MW-1:0] miss;
  logic          head_ok;
  logic [7:0]    cur_byte;
  logic          frame_good;

  assign cur_byte   = lanes[sel];
  assign cur_sel    = (state == ST_SEARCH && hit) ? hit_idx : sel;
  assign in_frame   = (state == ST_SYNC);
  assign frame_good = head_ok && (cur_byte[7:4] == 4'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SEARCH;
      sel <= '0;
      pos <= '0;
      good <= '0;
      miss <= '0;
      head_ok <= 1'b0;
      fa_stb <= 1'b0;
      nib_stb <= 1'b0;
    end else begin
      fa_stb <= 1'b0;
      nib_stb <= 1'b0;
      if (adv) begin
        pos <= (pos == PW'(FRAME_BYTES - 1)) ? '0 : pos + 1'b1;
        if (state == ST_SEARCH) begin
          if (hit) begin
            sel <= hit_idx;
            state <= ST_CHECK;
            good <= '0;
            head_ok <= 1'b1;
            pos <= PW'(1);
            fa_stb <= 1'b1;
          end
        end else begin
          if (pos == '0) begin
            head_ok <= (cur_byte == ALIGN_HEAD);
            fa_stb <= (cur_byte == ALIGN_HEAD);
          end
          if (pos == PW'(1)) begin
            if (frame_good) begin
              nib_stb <= 1'b1;
              miss <= '0;
              if (state == ST_CHECK) begin
                if (good == GW'(CONFIRM_FRAMES - 1)) state <= ST_SYNC;
                else good <= good + 1'b1;
              end
            end else if (state == ST_CHECK) begin
              state <= ST_SEARCH;
            end else if (miss == MW'(LOSS_FRAMES - 1)) begin
              state <= ST_SEARCH;
              miss <= '0;
            end else begin
              miss <= miss + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/e4_frame_aligner.sv
module e4_frame_aligner
  import e4fa_pkg::*;
#(
  parameter int FRAME_BYTES = 366,
  parameter int CONFIRM_FRAMES = 3,
  parameter int LOSS_FRAMES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic [LANE_IW-1:0] align_sel,
  output logic               in_frame,
  output logic               fa_found,
  output logic               nib_found
);
  logic               adv;
  lanes_t             lanes;
  logic               hit;
  logic [LANE_IW-1:0] hit_idx;
  logic [LANE_IW-1:0] cur_sel;

  assign in_ready = !out_valid || out_ready;
  assign adv = in_valid && in_ready;

  e4fa_window u_window (
    .clk(clk), .rst(rst), .adv(adv), .din(in_data), .lanes(lanes)
  );

  e4fa_detect u_detect (
    .lanes(lanes), .hit(hit), .hit_idx(hit_idx)
  );

  e4fa_ctrl #(
    .FRAME_BYTES(FRAME_BYTES),
    .CONFIRM_FRAMES(CONFIRM_FRAMES),
    .LOSS_FRAMES(LOSS_FRAMES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .adv(adv), .lanes(lanes), .hit(hit),
    .hit_idx(hit_idx), .sel(align_sel), .cur_sel(cur_sel),
    .in_frame(in_frame), .fa_stb(fa_found), .nib_stb(nib_found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_data <= lanes[cur_sel];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/e4fa_chk.sv
module e4fa_chk (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [2:0] align_sel,
  input logic       in_frame,
  input logic       fa_found,
  input logic       nib_found
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    in_frame |=> $stable(align_sel)); // R7
  AST_SYNC_ON_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(in_frame) |-> nib_found); // R5
  AST_HEAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    fa_found |=> !fa_found); // R2
  AST_LOSS_ON_BAD: assert property (@(posedge clk) disable iff (rst)
    $fell(in_frame) |-> !nib_found); // R8
endmodule

bind e4_frame_aligner e4fa_chk u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .align_sel(align_sel), .in_frame(in_frame),
  .fa_found(fa_found), .nib_found(nib_found)
);

// File: tb/e4_frame_aligner_bench.sv
module e4_frame_aligner_bench;
  localparam int FB = 366;
  localparam int FBITS = FB * 8;
  localparam logic [11:0] WORD = 12'b1111_1010_0000;

  typedef struct packed { logic chk; logic [7:0] val; } item_t;

  logic clk = 0, rst = 1, in_valid = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, in_frame, fa_found, nib_found;
  logic [7:0] out_data;
  logic [2:0] align_sel;

  int checks = 0, fails = 0, cyc = 0;
  int cur_s = 0, cur_k = 0, chk_from = 0;
  logic [15:0] fa_bad = 0, nib_bad = 0, spur = 0;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  e4_frame_aligner u_e4_frame_aligner (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .align_sel(align_sel), .in_frame(in_frame),
    .fa_found(fa_found), .nib_found(nib_found)
  );

  function automatic logic sbit(int j);
    int q, f;
    logic b;
    if (j < cur_s) return 1'b0;
    q = (j - cur_s) % FBITS;
    f = (j - cur_s) / FBITS;
    if (q < 12) begin
      b = WORD[11-q];
      if (fa_bad[f] && q == 0) b = 1'b0;
      if (nib_bad[f] && q == 8) b = 1'b1;
      return b;
    end
    if (spur[f] && q >= 100 && q < 112) return WORD[11-(q-100)];
    return ((q - 12) % 2 == 0);
  endfunction

  function automatic logic [7:0] bits_at(int start);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = sbit(start + i);
    return r;
  endfunction

  task automatic check(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    sb.delete();
    @(negedge clk);
    rst = 0;
  endtask

  task automatic send(int t);
    logic acc = 0;
    while (!acc) begin
      @(negedge clk);
      #2;
      out_ready = (cyc % 5 != 2);
      in_valid = (cyc % 7 != 4);
      in_data = bits_at(8 * t);
      #1;
      acc = in_valid && in_ready;
      if (acc) sb.push_back('{t >= chk_from, bits_at(8 * t - cur_k)});
    end
    @(posedge clk);
    #1;
    in_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    #2;
    out_ready = 1;
    repeat (4) @(posedge clk);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      if (!rst && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 unexpected output", out_data, 0);
        end else begin
          it = sb.pop_front();
          if (it.chk) check(out_data == it.val, "R3 aligned byte", out_data, it.val);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int ta, ts;
    do_reset();
    #1;
    check(out_valid == 0 && in_frame == 0, "R1 reset flags", {out_valid, in_frame}, 0);
    check(align_sel == 0 && fa_found == 0 && nib_found == 0, "R1 reset select",
          {align_sel, fa_found, nib_found}, 0);

    // R2: every offset, no bit errors
    for (int s = 0; s < 8; s++) begin
      do_reset();
      cur_s = s; fa_bad = 0; nib_bad = 0; spur = 0;
      ta = (s + 7) / 8; cur_k = 8 * ta - s; chk_from = ta;
      for (int t = 0; t <= ta + 1; t++) begin
        send(t);
        if (t == ta) begin
          check(align_sel == cur_k, "R2 offset select", align_sel, cur_k);
          check(fa_found == 1, "R2 head pulse", fa_found, 1);
        end
        if (t == ta + 1) check(nib_found == 1, "R4 nibble pulse", nib_found, 1);
      end
      drain();
    end

    // main run: sync, single error, spurious word, loss, reacquire
    do_reset();
    cur_s = 3; nib_bad = 0; spur = 16'h0020;
    fa_bad = 16'h0010 | 16'h03C0;
    ta = 1; cur_k = 5; chk_from = ta;
    ts = (cur_s + 5 * FBITS + 100 + 7) / 8;
    for (int t = 0; t <= ta + 4393; t++) begin
      send(t);
      if (t == ta + 2) begin : stall_probe
        logic [7:0] held;
        @(negedge clk); #2;
        out_ready = 0; in_valid = 1;
        #1;
        check(in_ready == 0, "R9 ready low in stall", in_ready, 0);
        held = out_data;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1 && out_data == held, "R9 data held", out_data, held);
        in_valid = 0;
      end
      if (t == ta + 732) check(in_frame == 0, "R5 not yet in sync", in_frame, 0);
      if (t == ta + 733) check(in_frame == 1 && nib_found == 1, "R5 sync declared", in_frame, 1);
      if (t == ta + 4 * FB + 1) check(in_frame == 1, "R8 single error tolerated", in_frame, 1);
      if (t == ts) check(fa_found == 0 && align_sel == 5, "R7 spurious ignored", align_sel, 5);
      if (t == ta + 9 * FB) check(in_frame == 1, "R8 three misses keep sync", in_frame, 1);
      if (t == ta + 9 * FB + 1) check(in_frame == 0, "R8 loss after four", in_frame, 0);
      if (t == ta + 10 * FB) check(fa_found == 1 && align_sel == 5, "R8 search resumed", align_sel, 5);
      if (t == ta + 4393) check(in_frame == 1, "R8 sync regained", in_frame, 1);
    end
    drain();

    // R4: bad trailing nibble releases the select
    do_reset();
    cur_s = 5; fa_bad = 0; spur = 0; nib_bad = 16'h0001;
    ta = 1; cur_k = 3; chk_from = ta;
    for (int t = 0; t <= ta + 1100; t++) begin
      send(t);
      if (t == ta + 1) check(nib_found == 0, "R4 bad nibble no pulse", nib_found, 0);
      if (t == ta + FB) check(fa_found == 1 && align_sel == 3, "R4 redetect", align_sel, 3);
      if (t == ta + 733) check(in_frame == 0, "R4 released select", in_frame, 0);
      if (t == ta + FB + 733) check(in_frame == 1, "R4 sync after release", in_frame, 1);
    end
    drain();

    // R6: missing word before sync returns to search
    do_reset();
    cur_s = 6; spur = 0; nib_bad = 0; fa_bad = 16'h0002;
    ta = 1; cur_k = 2; chk_from = ta;
    for (int t = 0; t <= ta + 1466; t++) begin
      send(t);
      if (t == ta + FB + 1) check(nib_found == 0, "R6 missing word", nib_found, 0);
      if (t == ta + 733) check(in_frame == 0, "R6 no early sync", in_frame, 0);
      if (t == ta + 2 * FB) check(fa_found == 1, "R6 search redetects", fa_found, 1);
      if (t == ta + 2 * FB + 732) check(in_frame == 0, "R6 before sync", in_frame, 0);
      if (t == ta + 2 * FB + 733) check(in_frame == 1, "R6 sync after restart", in_frame, 1);
    end
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule